// File: doc/BRIEF.md
# Call-Return Stack Sequencer

This block carries out the stack and control-transfer operations of a small 8-bit processor with a 16-bit program counter and a byte-wide data memory. A decoder presents an operation code, a 16-bit operand and the current PC, SP, flag byte (PSW), interrupt-enable bit and NMI-in-service bit, and pulses `start`. The sequencer latches these values. It then issues the byte reads and writes the operation needs, one memory access per cycle. After the last access it commits the new PC, SP, PSW, interrupt-enable, NMI-in-service and popped register-pair value, and raises `done` for one cycle.

The block handles these operations: a long call with a 16-bit target, a short call into the fixed 2 KiB page at 0800H, a vectored call through a table in page zero, a software break, and three return flavours. It also pushes and pops the flag byte or a 16-bit register pair. The memory port has a one-cycle synchronous read latency. A byte requested in one cycle is presented on `mem_rdata` in the next cycle, and the sequencer takes it in that same cycle while it issues the following access.

Top module: `stk_xfer_seq`

## Requirements
- R1: Operation code 0 (long call) writes the high byte of PC+3 to SP-1 and then the low byte to SP-2. It sets PC to `imm[15:0]` and SP to SP-2.
- R2: Operation code 1 (short call) pushes PC+2 in the same high-then-low order. It sets PC to binary 00001 followed by `imm[10:0]` and SP to SP-2.
- R3: Operation code 2 (table call) first reads address `imm[4:0]` zero-extended to 16 bits as the new PC low byte. It then reads that address plus 1 as the new PC high byte. After the reads it writes the high and low bytes of PC+1 to SP-1 and SP-2, and SP becomes SP-2.
- R4: Operation code 3 (break) writes PSW to SP-1, the high byte of PC+1 to SP-2 and the low byte of PC+1 to SP-3. It then reads 003EH as the PC low byte and 003FH as the PC high byte. SP becomes SP-3 and interrupt-enable is cleared.
- R5: Operation code 4 (return) reads the PC low byte at SP and the high byte at SP+1, and SP becomes SP+2.
- R6: Operation codes 5 (interrupt return) and 6 (break return) behave as a return and also read PSW from SP+2. SP becomes SP+3. Only code 5 clears NMI-in-service, and code 6 leaves it unchanged.
- R7: Operation code 7 writes PSW to SP-1 and SP becomes SP-1. Operation code 9 reads PSW from SP and SP becomes SP+1.
- R8: Operation code 8 writes `imm[15:8]` to SP-1 and then `imm[7:0]` to SP-2, and SP becomes SP-2. Operation code 10 reads the low byte at SP and the high byte at SP+1. It presents them on `pair_out`, and SP becomes SP+2.
- R9: All SP and stack-address arithmetic wraps modulo 2^16.
- R10: An operation with N accesses issues exactly one access per cycle in cycles 1..N after the start edge. `busy` is high in cycles 1..N+1. `done` is high only in cycle N+2, when `busy` is low, and the committed outputs change only in that cycle.
- R11: Operation codes 11 to 15 make no memory access. They raise `done` and `err` together in cycle 2, and the committed PC, SP, PSW, interrupt-enable and NMI-in-service equal the latched inputs.
- R12: The operation code and operands are latched at the start edge. `start` and input changes while `busy` is high have no effect on the accesses or results.
- R13: After reset, `busy`, `done`, `err` and `mem_req` are low and the committed PC and SP are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch an operation (taken only while idle) |
| op | input | 4 | Operation code |
| imm | input | 16 | Operand: call target, short or table address, or pair value to push |
| pc_in | input | 16 | Current program counter |
| sp_in | input | 16 | Current stack pointer |
| psw_in | input | 8 | Current flag byte |
| ie_in | input | 1 | Current interrupt-enable bit |
| nmis_in | input | 1 | Current NMI-in-service bit |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle commit pulse |
| err | output | 1 | Invalid operation code, valid with done |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Access byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, one cycle after the read request |
| pc_out | output | 16 | Committed program counter |
| sp_out | output | 16 | Committed stack pointer |
| psw_out | output | 8 | Committed flag byte |
| ie_out | output | 1 | Committed interrupt-enable bit |
| nmis_out | output | 1 | Committed NMI-in-service bit |
| pair_out | output | 16 | Register pair from the last pair pop |

## Verification
Capturing a returned read byte and issuing the next access happen in the same cycle. In a return, the SP byte lands while the SP+1 read goes out. In a table call, the vector high byte lands while the first stack write goes out. The bench memory returns a different byte for neighbouring addresses, so a capture that is dropped, swapped or taken one cycle late shows up as a wrong PC, PSW or pair. The full access sequence is also compared in order. Every operation code is swept with stack pointers chosen so that the pushes and pops wrap through 0000H, and with inputs scrambled and `start` re-pulsed while busy.

// File: rtl/stk_xfer_pkg.sv
package stk_xfer_pkg;

    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 8;
    localparam int OP_W      = 4;
    localparam int STEP_W    = 3;
    localparam int TBL_W     = 5;
    localparam int PAGE_W    = 11;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [OP_W-1:0]   opc_t;

    localparam addr_t VEC_LO_ADDR = addr_t'(16'h003E);
    localparam addr_t VEC_HI_ADDR = addr_t'(16'h003F);
    localparam logic [ADDR_W-PAGE_W-1:0] SHORT_PAGE = 5'b00001;

    typedef enum logic [OP_W-1:0] {
        OP_CALL_LONG  = 4'd0,
        OP_CALL_SHORT = 4'd1,
        OP_CALL_TABLE = 4'd2,
        OP_BREAK      = 4'd3,
        OP_RET        = 4'd4,
        OP_RET_INT    = 4'd5,
        OP_RET_BRK    = 4'd6,
        OP_PUSH_FLAGS = 4'd7,
        OP_PUSH_PAIR  = 4'd8,
        OP_POP_FLAGS  = 4'd9,
        OP_POP_PAIR   = 4'd10
    } op_e;

    typedef enum logic [2:0] {
        D_NONE = 3'd0,
        D_PCL  = 3'd1,
        D_PCH  = 3'd2,
        D_PSW  = 3'd3,
        D_PRL  = 3'd4,
        D_PRH  = 3'd5
    } dest_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_FIN  = 2'd2
    } state_e;

    typedef struct packed {
        logic  act;
        logic  we;
        addr_t addr;
        byte_t wdata;
        dest_e dest;
    } step_t;

    typedef struct packed {
        byte_t pcl;
        byte_t pch;
        byte_t psw;
        byte_t prl;
        byte_t prh;
    } gather_t;

    typedef struct packed {
        addr_t pc;
        addr_t sp;
        byte_t psw;
        logic  ie;
        logic  nmis;
        logic  err;
        logic  pair_ld;
        addr_t pair;
    } result_t;

    function automatic step_t mk_wr(input addr_t a, input byte_t d);
        step_t s;
        s.act   = 1'b1;
        s.we    = 1'b1;
        s.addr  = a;
        s.wdata = d;
        s.dest  = D_NONE;
        return s;
    endfunction

    function automatic step_t mk_rd(input addr_t a, input dest_e d);
        step_t s;
        s.act   = 1'b1;
        s.we    = 1'b0;
        s.addr  = a;
        s.wdata = '0;
        s.dest  = d;
        return s;
    endfunction

    function automatic logic [STEP_W-1:0] step_count(input opc_t op);
        case (op)
            OP_CALL_LONG, OP_CALL_SHORT, OP_RET,
            OP_PUSH_PAIR, OP_POP_PAIR:     return STEP_W'(2);
            OP_CALL_TABLE:                 return STEP_W'(4);
            OP_BREAK:                      return STEP_W'(5);
            OP_RET_INT, OP_RET_BRK:        return STEP_W'(3);
            OP_PUSH_FLAGS, OP_POP_FLAGS:   return STEP_W'(1);
            default:                       return STEP_W'(0);
        endcase
    endfunction

    function automatic addr_t ret_offset(input opc_t op);
        case (op)
            OP_CALL_LONG:  return addr_t'(3);
            OP_CALL_SHORT: return addr_t'(2);
            default:       return addr_t'(1);
        endcase
    endfunction

endpackage

// File: rtl/stk_step_plan.sv
module stk_step_plan
    import stk_xfer_pkg::*;
(
    input  opc_t                op,
    input  logic [STEP_W-1:0]   idx,
    input  addr_t               pc,
    input  addr_t               sp,
    input  byte_t               psw,
    input  addr_t               imm,
    output step_t               step
);

    addr_t ret_addr;
    addr_t tbl_addr;
    addr_t word;

    always_comb begin
        ret_addr = pc + ret_offset(op);
        tbl_addr = {{(ADDR_W-TBL_W){1'b0}}, imm[TBL_W-1:0]};
        word     = (op == OP_PUSH_PAIR) ? imm : ret_addr;
        step     = '0;
        case (op)
            OP_CALL_LONG, OP_CALL_SHORT, OP_PUSH_PAIR: begin
                case (idx)
                    3'd0:    step = mk_wr(sp - addr_t'(1), word[15:8]);
                    3'd1:    step = mk_wr(sp - addr_t'(2), word[7:0]);
                    default: step = '0;
                endcase
            end
            OP_CALL_TABLE: begin
                case (idx)
                    3'd0:    step = mk_rd(tbl_addr, D_PCL);
                    3'd1:    step = mk_rd(tbl_addr + addr_t'(1), D_PCH);
                    3'd2:    step = mk_wr(sp - addr_t'(1), ret_addr[15:8]);
                    3'd3:    step = mk_wr(sp - addr_t'(2), ret_addr[7:0]);
                    default: step = '0;
                endcase
            end
            OP_BREAK: begin
                case (idx)
                    3'd0:    step = mk_wr(sp - addr_t'(1), psw);
                    3'd1:    step = mk_wr(sp - addr_t'(2), ret_addr[15:8]);
                    3'd2:    step = mk_wr(sp - addr_t'(3), ret_addr[7:0]);
                    3'd3:    step = mk_rd(VEC_LO_ADDR, D_PCL);
                    3'd4:    step = mk_rd(VEC_HI_ADDR, D_PCH);
                    default: step = '0;
                endcase
            end
            OP_RET, OP_RET_INT, OP_RET_BRK: begin
                case (idx)
                    3'd0:    step = mk_rd(sp, D_PCL);
                    3'd1:    step = mk_rd(sp + addr_t'(1), D_PCH);
                    3'd2:    step = mk_rd(sp + addr_t'(2), D_PSW);
                    default: step = '0;
                endcase
            end
            OP_PUSH_FLAGS: begin
                if (idx == '0) step = mk_wr(sp - addr_t'(1), psw);
            end
            OP_POP_FLAGS: begin
                if (idx == '0) step = mk_rd(sp, D_PSW);
            end
            OP_POP_PAIR: begin
                case (idx)
                    3'd0:    step = mk_rd(sp, D_PRL);
                    3'd1:    step = mk_rd(sp + addr_t'(1), D_PRH);
                    default: step = '0;
                endcase
            end
            default: step = '0;
        endcase
    end

endmodule

// File: rtl/stk_byte_gather.sv
module stk_byte_gather
    import stk_xfer_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    clr,
    input  dest_e   cap_dest,
    input  byte_t   cap_data,
    output gather_t view
);

    gather_t slots_q;

    always_comb begin
        view = slots_q;
        case (cap_dest)
            D_PCL:   view.pcl = cap_data;
            D_PCH:   view.pch = cap_data;
            D_PSW:   view.psw = cap_data;
            D_PRL:   view.prl = cap_data;
            D_PRH:   view.prh = cap_data;
            default: view = slots_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            slots_q <= '0;
        end else begin
            slots_q <= view;
        end
    end

endmodule

// File: rtl/stk_commit.sv
module stk_commit
    import stk_xfer_pkg::*;
(
    input  opc_t    op,
    input  addr_t   pc,
    input  addr_t   sp,
    input  byte_t   psw,
    input  logic    ie,
    input  logic    nmis,
    input  addr_t   imm,
    input  gather_t bytes,
    output result_t res
);

    addr_t loaded_pc;

    always_comb begin
        loaded_pc   = {bytes.pch, bytes.pcl};
        res.pc      = pc;
        res.sp      = sp;
        res.psw     = psw;
        res.ie      = ie;
        res.nmis    = nmis;
        res.err     = 1'b0;
        res.pair_ld = 1'b0;
        res.pair    = {bytes.prh, bytes.prl};
        case (op)
            OP_CALL_LONG: begin
                res.pc = imm;
                res.sp = sp - addr_t'(2);
            end
            OP_CALL_SHORT: begin
                res.pc = {SHORT_PAGE, imm[PAGE_W-1:0]};
                res.sp = sp - addr_t'(2);
            end
            OP_CALL_TABLE: begin
                res.pc = loaded_pc;
                res.sp = sp - addr_t'(2);
            end
            OP_BREAK: begin
                res.pc = loaded_pc;
                res.sp = sp - addr_t'(3);
                res.ie = 1'b0;
            end
            OP_RET: begin
                res.pc = loaded_pc;
                res.sp = sp + addr_t'(2);
            end
            OP_RET_INT: begin
                res.pc   = loaded_pc;
                res.psw  = bytes.psw;
                res.sp   = sp + addr_t'(3);
                res.nmis = 1'b0;
            end
            OP_RET_BRK: begin
                res.pc  = loaded_pc;
                res.psw = bytes.psw;
                res.sp  = sp + addr_t'(3);
            end
            OP_PUSH_FLAGS: res.sp = sp - addr_t'(1);
            OP_PUSH_PAIR:  res.sp = sp - addr_t'(2);
            OP_POP_FLAGS: begin
                res.psw = bytes.psw;
                res.sp  = sp + addr_t'(1);
            end
            OP_POP_PAIR: begin
                res.pair_ld = 1'b1;
                res.sp      = sp + addr_t'(2);
            end
            default: res.err = 1'b1;
        endcase
    end

endmodule

// File: rtl/stk_xfer_seq.sv
module stk_xfer_seq
    import stk_xfer_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [3:0]  op,
    input  logic [15:0] imm,
    input  logic [15:0] pc_in,
    input  logic [15:0] sp_in,
    input  logic [7:0]  psw_in,
    input  logic        ie_in,
    input  logic        nmis_in,
    output logic        busy,
    output logic        done,
    output logic        err,
    output logic        mem_req,
    output logic        mem_we,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_wdata,
    input  logic [7:0]  mem_rdata,
    output logic [15:0] pc_out,
    output logic [15:0] sp_out,
    output logic [7:0]  psw_out,
    output logic        ie_out,
    output logic        nmis_out,
    output logic [15:0] pair_out
);

    state_e            state_q;
    opc_t              op_q;
    addr_t             imm_q, pc_q, sp_q;
    byte_t             psw_q;
    logic              ie_q, nmis_q;
    logic [STEP_W-1:0] idx_q;
    logic [STEP_W-1:0] n_steps;
    dest_e             dest_q;
    logic              done_q, err_q;
    addr_t             pc_r, sp_r, pair_r;
    byte_t             psw_r;
    logic              ie_r, nmis_r;

    step_t             step;
    gather_t           bytes;
    result_t           res;
    logic              accept;

    assign accept  = (state_q == S_IDLE) && start;
    assign n_steps = step_count(op_q);

    stk_step_plan u_plan (
        .op   (op_q),
        .idx  (idx_q),
        .pc   (pc_q),
        .sp   (sp_q),
        .psw  (psw_q),
        .imm  (imm_q),
        .step (step)
    );

    stk_byte_gather u_gather (
        .clk      (clk),
        .rst      (rst),
        .clr      (accept),
        .cap_dest (dest_q),
        .cap_data (mem_rdata),
        .view     (bytes)
    );

    stk_commit u_commit (
        .op    (op_q),
        .pc    (pc_q),
        .sp    (sp_q),
        .psw   (psw_q),
        .ie    (ie_q),
        .nmis  (nmis_q),
        .imm   (imm_q),
        .bytes (bytes),
        .res   (res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            op_q    <= '0;
            imm_q   <= '0;
            pc_q    <= '0;
            sp_q    <= '0;
            psw_q   <= '0;
            ie_q    <= 1'b0;
            nmis_q  <= 1'b0;
            idx_q   <= '0;
            dest_q  <= D_NONE;
        end else begin
            case (state_q)
                S_IDLE: begin
                    dest_q <= D_NONE;
                    if (start) begin
                        op_q    <= op;
                        imm_q   <= imm;
                        pc_q    <= pc_in;
                        sp_q    <= sp_in;
                        psw_q   <= psw_in;
                        ie_q    <= ie_in;
                        nmis_q  <= nmis_in;
                        idx_q   <= '0;
                        state_q <= (step_count(op) == '0) ? S_FIN : S_RUN;
                    end
                end
                S_RUN: begin
                    dest_q <= step.we ? D_NONE : step.dest;
                    if (idx_q == n_steps - STEP_W'(1)) begin
                        state_q <= S_FIN;
                    end else begin
                        idx_q <= idx_q + STEP_W'(1);
                    end
                end
                default: begin
                    dest_q  <= D_NONE;
                    state_q <= S_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            pc_r   <= '0;
            sp_r   <= '0;
            psw_r  <= '0;
            ie_r   <= 1'b0;
            nmis_r <= 1'b0;
            pair_r <= '0;
        end else begin
            done_q <= (state_q == S_FIN);
            err_q  <= (state_q == S_FIN) && res.err;
            if (state_q == S_FIN) begin
                pc_r   <= res.pc;
                sp_r   <= res.sp;
                psw_r  <= res.psw;
                ie_r   <= res.ie;
                nmis_r <= res.nmis;
                if (res.pair_ld) pair_r <= res.pair;
            end
        end
    end

    assign busy      = (state_q != S_IDLE);
    assign done      = done_q;
    assign err       = err_q;
    assign mem_req   = (state_q == S_RUN) && step.act;
    assign mem_we    = mem_req && step.we;
    assign mem_addr  = mem_req ? step.addr : '0;
    assign mem_wdata = mem_we ? step.wdata : '0;
    assign pc_out    = pc_r;
    assign sp_out    = sp_r;
    assign psw_out   = psw_r;
    assign ie_out    = ie_r;
    assign nmis_out  = nmis_r;
    assign pair_out  = pair_r;

endmodule

// File: rtl/stk_xfer_seq_chk.sv
module stk_xfer_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        done,
    input logic        err,
    input logic        mem_req,
    input logic [15:0] pc_out,
    input logic [15:0] sp_out,
    input logic [7:0]  psw_out,
    input logic        ie_out,
    input logic        nmis_out,
    input logic [3:0]  op_q
);

    // R10: accesses only while the operation is running
    p_req_in_busy_r10: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

    // R10: commit pulse lasts one cycle
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10: commit follows a busy cycle and is not itself busy
    p_done_after_busy_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(busy) && !busy));

    // R10: committed state moves only with the commit pulse
    p_hold_outputs_r10: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(pc_out) && $stable(sp_out) && $stable(psw_out)
                   && $stable(ie_out) && $stable(nmis_out)));

    // R11: error only together with the commit pulse
    p_err_with_done_r11: assert property (@(posedge clk) disable iff (rst)
        err |-> done);

    // R11: an invalid code issued no access in the cycle before commit
    p_err_no_access_r11: assert property (@(posedge clk) disable iff (rst)
        err |-> !$past(mem_req));

    // R12: the latched operation does not move while running
    p_op_latched_r12: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(op_q));

endmodule

bind stk_xfer_seq stk_xfer_seq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .mem_req  (mem_req),
    .pc_out   (pc_out),
    .sp_out   (sp_out),
    .psw_out  (psw_out),
    .ie_out   (ie_out),
    .nmis_out (nmis_out),
    .op_q     (op_q)
);

// File: tb/stk_xfer_seq_tb.sv
module stk_xfer_seq_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [3:0]  op = '0;
    logic [15:0] imm = '0, pc_in = '0, sp_in = '0;
    logic [7:0]  psw_in = '0;
    logic        ie_in = 1'b0, nmis_in = 1'b0;
    logic        busy, done, err, mem_req, mem_we;
    logic [15:0] mem_addr, pc_out, sp_out, pair_out;
    logic [7:0]  mem_wdata, psw_out;
    logic [7:0]  mem_rdata = '0;
    logic        ie_out, nmis_out;

    int checks = 0;
    int fails  = 0;

    logic [15:0] log_addr [8];
    logic [7:0]  log_data [8];
    logic        log_we   [8];
    int          n_log = 0;

    always #4 clk = ~clk;

    stk_xfer_seq u_dut (
        .clk(clk), .rst(rst), .start(start), .op(op), .imm(imm),
        .pc_in(pc_in), .sp_in(sp_in), .psw_in(psw_in), .ie_in(ie_in),
        .nmis_in(nmis_in), .busy(busy), .done(done), .err(err),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .pc_out(pc_out),
        .sp_out(sp_out), .psw_out(psw_out), .ie_out(ie_out),
        .nmis_out(nmis_out), .pair_out(pair_out)
    );

    function automatic logic [7:0] memf(input logic [15:0] a);
        return a[7:0] ^ {a[14:8], a[15]} ^ 8'h5A;
    endfunction

    always @(posedge clk) begin
        if (mem_req && !mem_we) mem_rdata <= memf(mem_addr);
        if (mem_req) begin
            if (n_log < 8) begin
                log_addr[n_log] = mem_addr;
                log_data[n_log] = mem_wdata;
                log_we[n_log]   = mem_we;
            end
            n_log = n_log + 1;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [3:0] c, input logic [15:0] i,
                          input logic [15:0] pc, input logic [15:0] sp,
                          input logic [7:0] psw, input logic ie,
                          input logic nm, input logic restart, input logic wrap);
        logic [15:0] e_addr [8];
        logic [7:0]  e_data [8];
        logic        e_we   [8];
        int          ne;
        logic [15:0] ret, tbl, w, e_pc, e_sp, e_pair;
        logic [7:0]  e_psw;
        logic        e_ie, e_nm, e_err, pair_chk;
        string       rq;
        int          cyc;
        logic        busy_ok;
        logic        acc_ok;

        ne = 0; e_pc = pc; e_sp = sp; e_psw = psw; e_ie = ie; e_nm = nm;
        e_err = 1'b0; pair_chk = 1'b0; e_pair = '0;
        ret = pc + ((c == 4'd0) ? 16'd3 : (c == 4'd1) ? 16'd2 : 16'd1);
        tbl = {11'd0, i[4:0]};
        for (int k = 0; k < 8; k++) begin
            e_addr[k] = '0; e_data[k] = '0; e_we[k] = 1'b0;
        end
        case (c)
            4'd0, 4'd1, 4'd8: begin
                rq = (c == 4'd0) ? "R1" : (c == 4'd1) ? "R2" : "R8";
                w = (c == 4'd8) ? i : ret;
                e_we[0] = 1; e_addr[0] = sp - 16'd1; e_data[0] = w[15:8];
                e_we[1] = 1; e_addr[1] = sp - 16'd2; e_data[1] = w[7:0];
                ne = 2; e_sp = sp - 16'd2;
                if (c == 4'd0) e_pc = i;
                if (c == 4'd1) e_pc = {5'b00001, i[10:0]};
            end
            4'd2: begin
                rq = "R3";
                e_addr[0] = tbl; e_addr[1] = tbl + 16'd1;
                e_we[2] = 1; e_addr[2] = sp - 16'd1; e_data[2] = ret[15:8];
                e_we[3] = 1; e_addr[3] = sp - 16'd2; e_data[3] = ret[7:0];
                ne = 4; e_sp = sp - 16'd2;
                e_pc = {memf(tbl + 16'd1), memf(tbl)};
            end
            4'd3: begin
                rq = "R4";
                e_we[0] = 1; e_addr[0] = sp - 16'd1; e_data[0] = psw;
                e_we[1] = 1; e_addr[1] = sp - 16'd2; e_data[1] = ret[15:8];
                e_we[2] = 1; e_addr[2] = sp - 16'd3; e_data[2] = ret[7:0];
                e_addr[3] = 16'h003E; e_addr[4] = 16'h003F;
                ne = 5; e_sp = sp - 16'd3; e_ie = 1'b0;
                e_pc = {memf(16'h003F), memf(16'h003E)};
            end
            4'd4, 4'd5, 4'd6: begin
                rq = (c == 4'd4) ? "R5" : "R6";
                e_addr[0] = sp; e_addr[1] = sp + 16'd1;
                e_pc = {memf(sp + 16'd1), memf(sp)};
                if (c == 4'd4) begin
                    ne = 2; e_sp = sp + 16'd2;
                end else begin
                    e_addr[2] = sp + 16'd2; ne = 3; e_sp = sp + 16'd3;
                    e_psw = memf(sp + 16'd2);
                    if (c == 4'd5) e_nm = 1'b0;
                end
            end
            4'd7: begin
                rq = "R7";
                e_we[0] = 1; e_addr[0] = sp - 16'd1; e_data[0] = psw;
                ne = 1; e_sp = sp - 16'd1;
            end
            4'd9: begin
                rq = "R7";
                e_addr[0] = sp; ne = 1; e_sp = sp + 16'd1;
                e_psw = memf(sp);
            end
            4'd10: begin
                rq = "R8";
                e_addr[0] = sp; e_addr[1] = sp + 16'd1; ne = 2;
                e_sp = sp + 16'd2; pair_chk = 1'b1;
                e_pair = {memf(sp + 16'd1), memf(sp)};
            end
            default: begin
                rq = "R11"; e_err = 1'b1;
            end
        endcase

        @(negedge clk);
        n_log = 0;
        op = c; imm = i; pc_in = pc; sp_in = sp; psw_in = psw;
        ie_in = ie; nmis_in = nm; start = 1'b1;
        @(negedge clk);
        cyc = 1;
        busy_ok = 1'b1;
        start = restart;
        op = ~c; imm = ~i; pc_in = ~pc; sp_in = ~sp; psw_in = ~psw;
        ie_in = ~ie; nmis_in = ~nm;
        while (!done && cyc < 20) begin
            if (busy !== 1'b1) busy_ok = 1'b0;
            @(negedge clk);
            start = 1'b0;
            cyc++;
        end
        chk("R10", "done cycle", cyc, ne + 2);
        chk("R10", "busy profile", {busy_ok, busy}, 2'b10);
        if (cyc >= 20) begin
            $display("FAIL R10 watchdog: actual no done expected done");
            checks++; fails++;
        end
        chk(rq, "err", err, e_err);
        chk(rq, "pc", pc_out, e_pc);
        chk(wrap ? "R9" : rq, "sp", sp_out, e_sp);
        chk(rq, "psw", psw_out, e_psw);
        chk(rq, "ie", ie_out, e_ie);
        chk(rq, "nmis", nmis_out, e_nm);
        if (pair_chk) chk("R8", "pair", pair_out, e_pair);
        chk(e_err ? "R11" : "R10", "access count", n_log, ne);
        acc_ok = 1'b1;
        for (int k = 0; k < ne && k < 8; k++) begin
            if (log_we[k] !== e_we[k] || log_addr[k] !== e_addr[k] ||
                (e_we[k] && log_data[k] !== e_data[k])) acc_ok = 1'b0;
        end
        chk(restart ? "R12" : rq, "access sequence", acc_ok, 1'b1);
        @(negedge clk);
        chk("R10", "single done", done, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R13", "busy", busy, 1'b0);
        chk("R13", "done", done, 1'b0);
        chk("R13", "err", err, 1'b0);
        chk("R13", "mem_req", mem_req, 1'b0);
        chk("R13", "pc/sp", {pc_out, sp_out}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        for (int c = 0; c < 16; c++) begin
            run_op(c[3:0], 16'hBEEF, 16'h1234, 16'h0100, 8'hA5, 1'b1, 1'b1, 1'b0, 1'b0);
            run_op(c[3:0], 16'h07C3, 16'hFFFE, 16'h0001, 8'h3C, 1'b1, 1'b1, 1'b0, 1'b1);
            run_op(c[3:0], 16'h001F, 16'h0000, 16'hFFFF, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
            run_op(c[3:0], 16'h5A5A, 16'h7FFF, 16'h8000, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b0);
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #1600000;
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule